// File: doc/BRIEF.md
# Audio Sample DMA Channel

This block is one direction of an audio sample DMA engine. In playback form it reads bytes from memory and hands them to an audio sample sink. In capture form it takes bytes from an audio sample source and writes them to memory. A single parameter picks the direction, and the same byte mover serves both. The block moves bytes through a byte-wide request/acknowledge memory port and a byte-wide valid/ready stream. Samples are 16-bit signed stereo at 48 kHz, so one frame is four bytes. The stream carries raw bytes, and codec framing is left to the logic around the block.

Software programs a start address, a remaining byte count and an enable bit. While the channel is enabled, it runs bursts back to back. The length of each burst is the smallest of three values: the remaining count, the byte level the audio side reports (free space for playback, bytes held for capture), and a chunk cap. Every byte that moves raises the address by one and lowers the remaining count by one. When a burst ends with the channel enabled and the count at exactly zero, a one-clock completion pulse fires. Writing a new count arms the channel for the next buffer.

Stream rules. Between bytes, the mover looks at the audio side once. A sink that is not ready, or a source that is not valid, at that moment ends the burst early. After the playback side has fetched a byte, it holds `snk_valid` and `snk_data` until `snk_ready` is seen. In capture mode, `src_ready` is high for one cycle, only at a byte boundary, and only while `src_valid` is high.

Top module: `aud_dma_chan`

## Requirements
- R1: After reset, `cur_addr`, `cur_rem` and `stream_on` are 0, and `done_irq`, `mem_req` and `snk_valid` are low.
- R2: A burst moves at most min(`cur_rem`, `aud_level`, CHUNK) bytes. When that minimum is 0, no memory request is made and the count does not change.
- R3: Each byte moved adds 1 to `cur_addr` and subtracts 1 from `cur_rem`.
- R4: In playback (CAPTURE=0), the channel reads memory at `cur_addr` with `mem_we`=0 and hands each fetched byte to the sink in address order. `snk_valid` and `snk_data` hold steady until `snk_ready` is seen.
- R5: In capture (CAPTURE=1), each accepted source byte is written with `mem_we`=1 to the next address, in arrival order.
- R6: A sink that is not ready, or a source that is not valid, at a byte boundary ends the burst. Only the bytes already moved are counted.
- R7: `done_irq` is high for exactly one clock after a burst that ends while enabled with `cur_rem`=0. It does not repeat while the count stays at 0, and it never fires for a burst that moved nothing.
- R8: `stream_on` follows the last written enable value. No burst starts while disabled. Clearing the enable during a burst lets that burst finish and starts no further burst.
- R9: Address and count writes take effect only while no burst is running and are ignored during a burst. A count write while enabled starts a new buffer.
- R10: `mem_req` and `mem_addr` hold steady from the start of a request until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_val | input | 1 | Enable value to write |
| cfg_addr_we | input | 1 | Write strobe for the address register |
| cfg_rem_we | input | 1 | Write strobe for the remaining-count register |
| cfg_wdata | input | AW | Write data; the count takes the low RW bits |
| stream_on | output | 1 | Audio stream active (enable bit) |
| cur_addr | output | AW | Current byte address |
| cur_rem | output | RW | Bytes left in the buffer |
| done_irq | output | 1 | One-clock buffer-complete pulse |
| aud_level | input | LW | Bytes the audio side can accept (playback) or supply (capture) |
| snk_valid | output | 1 | Playback byte valid |
| snk_ready | input | 1 | Sink ready |
| snk_data | output | 8 | Playback byte |
| src_valid | input | 1 | Capture byte valid |
| src_ready | output | 1 | Capture byte taken |
| src_data | input | 8 | Capture byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write (capture), 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench builds two instances, one with CAPTURE=0 and one with CAPTURE=1, both with AW=16, RW=12, LW=8 and CHUNK=4. The small chunk cap means a 10-byte buffer fed with an 8-byte audio level has to split into bursts. Clearing the enable during a held first burst then shows that exactly four bytes move and the channel stops. The test also stalls the memory acknowledge to keep a burst open, so the bench can show that address and count writes are ignored during a burst. It runs a zero audio level and a stalled stream to show that empty bursts move nothing and raise no interrupt.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_CHECK = 2'd1,
    MV_MEM   = 2'd2,
    MV_HAND  = 2'd3
  } mv_state_e;
endpackage

// File: rtl/aud_dma_sizer.sv
// Burst length: smallest of remaining count, audio level and chunk cap.
module aud_dma_sizer #(
  parameter int RW    = 24,
  parameter int LW    = 16,
  parameter int CHUNK = 4096,
  localparam int CW   = $clog2(CHUNK + 1)
) (
  input  logic [RW-1:0] rem,
  input  logic [LW-1:0] level,
  output logic [CW-1:0] len
);
  logic [31:0] r_ext, l_ext, m_val;

  always_comb begin
    r_ext = 32'(rem);
    l_ext = 32'(level);
    m_val = (r_ext < l_ext) ? r_ext : l_ext;
    if (m_val > 32'(CHUNK)) m_val = 32'(CHUNK);
    len = CW'(m_val);
  end
endmodule

// File: rtl/aud_dma_mover.sv
// Byte mover: one burst of up to len bytes between memory and audio stream.
module aud_dma_mover
  import aud_dma_pkg::*;
#(
  parameter bit CAPTURE = 1'b0,
  parameter int CW      = 13,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          moved,
  output logic          burst_end,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic [7:0]    snk_data,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [7:0]    src_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);
  mv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic [7:0]  data_q;
  logic        ld_data;
  logic [7:0]  data_in;

  always_comb begin
    state_d   = state_q;
    moved     = 1'b0;
    burst_end = 1'b0;
    src_ready = 1'b0;
    snk_valid = 1'b0;
    mem_req   = 1'b0;
    ld_data   = 1'b0;
    data_in   = CAPTURE ? src_data : mem_rdata;
    case (state_q)
      MV_IDLE: if (start) state_d = MV_CHECK;
      MV_CHECK: begin
        if (cnt_q == '0) begin
          burst_end = 1'b1;
          state_d   = MV_IDLE;
        end else if (CAPTURE) begin
          if (src_valid) begin
            src_ready = 1'b1;
            ld_data   = 1'b1;
            state_d   = MV_MEM;
          end else begin
            burst_end = 1'b1;
            state_d   = MV_IDLE;
          end
        end else if (snk_ready) begin
          state_d = MV_MEM;
        end else begin
          burst_end = 1'b1;
          state_d   = MV_IDLE;
        end
      end
      MV_MEM: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (CAPTURE) begin
            moved   = 1'b1;
            state_d = MV_CHECK;
          end else begin
            ld_data = 1'b1;
            state_d = MV_HAND;
          end
        end
      end
      MV_HAND: begin
        snk_valid = 1'b1;
        if (snk_ready) begin
          moved   = 1'b1;
          state_d = MV_CHECK;
        end
      end
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == MV_IDLE && start) cnt_q <= len;
      else if (moved)                  cnt_q <= cnt_q - 1'b1;
      if (ld_data) data_q <= data_in;
    end
  end

  assign busy      = (state_q != MV_IDLE);
  assign mem_we    = CAPTURE;
  assign mem_addr  = cur_addr;
  assign mem_wdata = data_q;
  assign snk_data  = data_q;

  p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid && !snk_ready |=> snk_valid && $stable(snk_data));
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_burst_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MV_IDLE) && start |=> cnt_q != '0);
endmodule

// File: rtl/aud_dma_regs.sv
// Enable, address and remaining registers plus completion pulse.
module aud_dma_regs #(
  parameter int AW = 32,
  parameter int RW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en_we,
  input  logic          cfg_en_val,
  input  logic          cfg_addr_we,
  input  logic          cfg_rem_we,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          moved,
  input  logic          burst_end,
  output logic          en_q,
  output logic [AW-1:0] addr_q,
  output logic [RW-1:0] rem_q,
  output logic          irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_en_we) en_q <= cfg_en_val;
      if (!busy && cfg_addr_we) addr_q <= cfg_wdata;
      else if (moved)           addr_q <= addr_q + 1'b1;
      if (!busy && cfg_rem_we)  rem_q <= cfg_wdata[RW-1:0];
      else if (moved)           rem_q <= rem_q - 1'b1;
      irq_q <= burst_end && en_q && (rem_q == '0);
    end
  end

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> rem_q == '0);
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> addr_q == $past(addr_q) + 1'b1);
  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !moved |=> $stable(addr_q) && $stable(rem_q));
endmodule

// File: rtl/aud_dma_chan.sv
// One direction of an audio sample DMA engine.
module aud_dma_chan #(
  parameter bit CAPTURE = 1'b0,
  parameter int AW      = 32,
  parameter int RW      = 24,
  parameter int LW      = 16,
  parameter int CHUNK   = 4096,
  localparam int CW     = $clog2(CHUNK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en_we,
  input  logic          cfg_en_val,
  input  logic          cfg_addr_we,
  input  logic          cfg_rem_we,
  input  logic [AW-1:0] cfg_wdata,
  output logic          stream_on,
  output logic [AW-1:0] cur_addr,
  output logic [RW-1:0] cur_rem,
  output logic          done_irq,
  input  logic [LW-1:0] aud_level,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic [7:0]    snk_data,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [7:0]    src_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);
  logic          busy, moved, burst_end, start, en_q;
  logic [CW-1:0] len;

  aud_dma_regs #(.AW(AW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_en_we(cfg_en_we), .cfg_en_val(cfg_en_val),
    .cfg_addr_we(cfg_addr_we), .cfg_rem_we(cfg_rem_we), .cfg_wdata(cfg_wdata),
    .busy(busy), .moved(moved), .burst_end(burst_end),
    .en_q(en_q), .addr_q(cur_addr), .rem_q(cur_rem), .irq_q(done_irq)
  );

  aud_dma_sizer #(.RW(RW), .LW(LW), .CHUNK(CHUNK)) u_sizer (
    .rem(cur_rem), .level(aud_level), .len(len)
  );

  assign start     = !busy && en_q && (len != '0) && !cfg_addr_we && !cfg_rem_we;
  assign stream_on = en_q;

  aud_dma_mover #(.CAPTURE(CAPTURE), .CW(CW), .AW(AW)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .cur_addr(cur_addr),
    .busy(busy), .moved(moved), .burst_end(burst_end),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  p_off_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !stream_on |=> !busy);
  p_zero_level_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (aud_level == '0) |=> !busy);
endmodule

// File: tb/test_aud_dma_chan.sv
`timescale 1ns/1ps
module test_aud_dma_chan;
  localparam int AW = 16, RW = 12, LW = 8, CHUNK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // playback instance signals
  logic p_en_we = 0, p_en_v = 0, p_a_we = 0, p_r_we = 0;
  logic [AW-1:0] p_wd = '0;
  logic p_on, p_irq, p_snk_valid, p_snk_ready = 0, p_src_ready;
  logic [AW-1:0] p_addr, p_maddr;
  logic [RW-1:0] p_rem;
  logic [7:0] p_snk_data, p_wdata, p_rdata;
  logic [LW-1:0] p_level = '0;
  logic p_req, p_we, p_ack = 0, p_hold = 0;

  // capture instance signals
  logic c_en_we = 0, c_en_v = 0, c_a_we = 0, c_r_we = 0;
  logic [AW-1:0] c_wd = '0;
  logic c_on, c_irq, c_snk_valid, c_src_valid = 0, c_src_ready;
  logic [AW-1:0] c_addr, c_maddr;
  logic [RW-1:0] c_rem;
  logic [7:0] c_snk_data, c_wdata, c_src_data = 8'hA0;
  logic [LW-1:0] c_level = '0;
  logic c_req, c_we, c_ack = 0;

  aud_dma_chan #(.CAPTURE(1'b0), .AW(AW), .RW(RW), .LW(LW), .CHUNK(CHUNK)) i_aud_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_en_we(p_en_we), .cfg_en_val(p_en_v),
    .cfg_addr_we(p_a_we), .cfg_rem_we(p_r_we), .cfg_wdata(p_wd),
    .stream_on(p_on), .cur_addr(p_addr), .cur_rem(p_rem), .done_irq(p_irq),
    .aud_level(p_level), .snk_valid(p_snk_valid), .snk_ready(p_snk_ready),
    .snk_data(p_snk_data), .src_valid(1'b0), .src_ready(p_src_ready), .src_data(8'h00),
    .mem_req(p_req), .mem_we(p_we), .mem_addr(p_maddr), .mem_wdata(p_wdata),
    .mem_rdata(p_rdata), .mem_ack(p_ack));

  aud_dma_chan #(.CAPTURE(1'b1), .AW(AW), .RW(RW), .LW(LW), .CHUNK(CHUNK)) i_aud_dma_chan_cap (
    .clk(clk), .rst_n(rst_n), .cfg_en_we(c_en_we), .cfg_en_val(c_en_v),
    .cfg_addr_we(c_a_we), .cfg_rem_we(c_r_we), .cfg_wdata(c_wd),
    .stream_on(c_on), .cur_addr(c_addr), .cur_rem(c_rem), .done_irq(c_irq),
    .aud_level(c_level), .snk_valid(c_snk_valid), .snk_ready(1'b1),
    .snk_data(c_snk_data), .src_valid(c_src_valid), .src_ready(c_src_ready), .src_data(c_src_data),
    .mem_req(c_req), .mem_we(c_we), .mem_addr(c_maddr), .mem_wdata(c_wdata),
    .mem_rdata(8'h00), .mem_ack(c_ack));

  // memory models: acknowledge one cycle after a request
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  assign p_rdata = mem_byte(p_maddr);
  always_ff @(posedge clk) p_ack <= p_req && !p_ack && !p_hold;
  always_ff @(posedge clk) c_ack <= c_req && !c_ack;
  always_ff @(posedge clk) if (c_src_valid && c_src_ready) c_src_data <= c_src_data + 8'd1;

  // scoreboard queues
  logic [7:0]  q_play[$];
  logic [23:0] q_cap[$];
  int p_irqs = 0, c_irqs = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitors, sampling at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (p_irq) p_irqs++;
    if (c_irq) c_irqs++;
    if (p_snk_valid && p_snk_ready) begin
      if (q_play.size() == 0) chk("R4 unexpected sink byte", {24'h0, p_snk_data}, 32'hFFFF_FFFF);
      else chk("R4 sink byte", {24'h0, p_snk_data}, {24'h0, q_play.pop_front()});
    end
    if (c_req && c_ack) begin
      chk("R5 capture write enable", {31'h0, c_we}, 32'h1);
      if (q_cap.size() == 0) chk("R5 unexpected memory write", {8'h0, c_maddr, c_wdata}, 32'hFFFF_FFFF);
      else chk("R5 memory write", {8'h0, c_maddr, c_wdata}, {8'h0, q_cap.pop_front()});
    end
  end

  // drivers
  task automatic p_cfg(input bit ew, input bit ev, input bit aw, input bit rw, input logic [AW-1:0] d);
    @(posedge clk); #1;
    p_en_we = ew; p_en_v = ev; p_a_we = aw; p_r_we = rw; p_wd = d;
    @(posedge clk); #1;
    p_en_we = 0; p_a_we = 0; p_r_we = 0;
  endtask
  task automatic c_cfg(input bit ew, input bit ev, input bit aw, input bit rw, input logic [AW-1:0] d);
    @(posedge clk); #1;
    c_en_we = ew; c_en_v = ev; c_a_we = aw; c_r_we = rw; c_wd = d;
    @(posedge clk); #1;
    c_en_we = 0; c_a_we = 0; c_r_we = 0;
  endtask
  task automatic push_play(input logic [AW-1:0] base, input int n);
    for (int i = 0; i < n; i++) q_play.push_back(mem_byte(base + AW'(i)));
  endtask
  task automatic push_cap(input logic [AW-1:0] base, input logic [7:0] d0, input int n);
    for (int i = 0; i < n; i++) q_cap.push_back({base + AW'(i), d0 + 8'(i)});
  endtask
  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(3);
    #1 rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk("R1 addr", 32'(p_addr), 0);
    chk("R1 rem", 32'(p_rem), 0);
    chk("R1 enable", {31'h0, p_on}, 0);
    chk("R1 outputs", {29'h0, p_irq, p_req, p_snk_valid}, 0);

    // playback: one full buffer (R2 R3 R4 R7)
    p_level = 8; p_snk_ready = 1;
    p_cfg(0, 0, 1, 0, 16'h0100);
    push_play(16'h0100, 6);
    p_cfg(0, 0, 0, 1, 16'd6);
    p_cfg(1, 1, 0, 0, 0);
    chk("R8 stream_on", {31'h0, p_on}, 1);
    cycles(80);
    chk("R3 rem after buffer", 32'(p_rem), 0);
    chk("R3 addr after buffer", 32'(p_addr), 32'h106);
    chk("R7 one pulse", p_irqs, 1);
    chk("R4 all bytes seen", q_play.size(), 0);
    cycles(40);
    chk("R7 no repeat at zero", p_irqs, 1);

    // zero audio level: nothing moves (R2)
    p_level = 0;
    p_cfg(0, 0, 0, 1, 16'd5);
    cycles(40);
    chk("R2 zero level rem", 32'(p_rem), 5);
    chk("R2 zero level no irq", p_irqs, 1);

    // sink stalled: bursts end empty (R6)
    p_level = 8; p_snk_ready = 0;
    cycles(40);
    chk("R6 stalled rem", 32'(p_rem), 5);
    chk("R6 stalled addr", 32'(p_addr), 32'h106);
    chk("R7 no irq on empty burst", p_irqs, 1);
    push_play(16'h0106, 5);
    p_snk_ready = 1;
    cycles(60);
    chk("R9 re-armed buffer done", 32'(p_rem), 0);
    chk("R7 second pulse", p_irqs, 2);

    // chunk cap, busy writes ignored, disable mid-burst (R2 R8 R9)
    p_hold = 1;
    push_play(16'h010B, 4);
    p_cfg(0, 0, 0, 1, 16'd10);
    cycles(10);
    p_cfg(0, 0, 0, 1, 16'd3);
    p_cfg(0, 0, 1, 0, 16'h0000);
    p_cfg(1, 0, 0, 0, 0);
    chk("R8 stream off", {31'h0, p_on}, 0);
    p_hold = 0;
    cycles(60);
    chk("R2 chunk cap rem", 32'(p_rem), 6);
    chk("R9 busy addr write ignored", 32'(p_addr), 32'h10F);
    chk("R7 no irq when short", p_irqs, 2);
    chk("R8 burst drained", q_play.size(), 0);
    cycles(30);
    chk("R8 stays stopped", 32'(p_rem), 6);
    push_play(16'h010F, 6);
    p_cfg(1, 1, 0, 0, 0);
    cycles(80);
    chk("R3 resumed rem", 32'(p_rem), 0);
    chk("R3 resumed addr", 32'(p_addr), 32'h115);
    chk("R7 third pulse", p_irqs, 3);

    // capture (R5 R6 R7)
    c_level = 16; c_src_valid = 1;
    c_cfg(0, 0, 1, 0, 16'h0200);
    push_cap(16'h0200, c_src_data, 5);
    c_cfg(0, 0, 0, 1, 16'd5);
    c_cfg(1, 1, 0, 0, 0);
    cycles(60);
    chk("R5 capture rem", 32'(c_rem), 0);
    chk("R5 capture addr", 32'(c_addr), 32'h205);
    chk("R7 capture pulse", c_irqs, 1);
    c_src_valid = 0;
    c_cfg(0, 0, 0, 1, 16'd3);
    cycles(40);
    chk("R6 source idle rem", 32'(c_rem), 3);
    chk("R6 source idle no irq", c_irqs, 1);
    push_cap(16'h0205, c_src_data, 3);
    @(posedge clk); #1 c_src_valid = 1;
    cycles(50);
    chk("R5 capture second rem", 32'(c_rem), 0);
    chk("R5 capture queue drained", q_cap.size(), 0);
    chk("R7 capture second pulse", c_irqs, 2);

    finish_run();
  end
endmodule